// File: doc/BRIEF.md
# Colour-Depth Pixel Serializer

This block turns one fetched display byte into a run of 3-bit RGB pixels for the beam. Depending on the selected colour depth, the byte holds eight 1-bit, four 2-bit or two 4-bit logical pixels. A multi-bit pixel does not sit in a contiguous field. Its bits are spread across the byte, so the block gathers them from several positions. Each logical pixel is held on the output for 1, 2 or 4 beam positions, which sets the horizontal scale. The logical colour index drives the three colour lines directly, with no palette lookup.

The byte arrives over a valid/ready handshake. The block can accept a byte only in a cycle where the fetch-phase strobe is high and no output burst is running. A producer that raises valid at any other time is held off: its byte stays on the bus until a cycle where ready is high. Once a byte is accepted, a burst starts on the next cycle. The burst walks through the logical pixels as the beam x position crosses scale boundaries. It stops at the next 8-position boundary of x. A row-gap input blanks the output and freezes the burst while it is high.

Top module: `pixel_serializer`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, no burst is active, rgb is 3'b000, and byte_ready equals phase0.
- R2: byte_ready is high exactly when phase0 is high and no burst is active. A byte is accepted only when byte_valid and byte_ready are both high at a clock edge. When byte_valid is high and byte_ready is low, the byte is not taken and the output is unaffected.
- R3: With depth_sel = 0 (1 bit per pixel), pixel index i (0..7) takes bit 7-i as its colour index.
- R4: With depth_sel = 1 (2 bits per pixel), pixel index i (0..3, taken as the index modulo 4) has bit 7-i as its upper index bit and bit 3-i as its lower index bit.
- R5: With depth_sel = 2 or 3 (4 bits per pixel), pixel index 0 is built from bits 7,5,3,1 (MSB first) and pixel index 1 from bits 6,4,2,0. The pixel index is taken modulo 2.
- R6: rgb[0] (red) carries colour index bit 0, rgb[1] (green) carries bit 1, and rgb[2] (blue) carries bit 2. Index bit 3 is dropped.
- R7: scale_sel = 0, 1 and 2 or 3 give scales of 1, 2 and 4. At a clock edge where a burst is active and row_gap is low, the pixel index advances by one when beam_x modulo the scale equals scale-1.
- R8: At a clock edge where a burst is active, row_gap is low and beam_x[2:0] = 7, the burst ends. The output is black from the next cycle on.
- R9: While no burst is active, rgb is 3'b000.
- R10: While row_gap is high, rgb is 3'b000, and at such edges the burst's pixel index and active state do not change.
- R11: An accepted byte starts a burst on the next cycle with pixel index 0. The load edge itself does not advance the index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_byte | input | 8 | Display byte offered by the fetch logic |
| byte_valid | input | 1 | pix_byte holds a byte to be taken |
| byte_ready | output | 1 | Block accepts the byte this cycle |
| depth_sel | input | 2 | 0: 1 bpp, 1: 2 bpp, 2/3: 4 bpp |
| scale_sel | input | 2 | 0: x1, 1: x2, 2/3: x4 |
| phase0 | input | 1 | Fetch-ring phase-0 strobe |
| beam_x | input | X_W (10) | Current horizontal beam position |
| row_gap | input | 1 | Row-spacing line: blank and hold |
| rgb | output | 3 | Pixel colour {blue, green, red} |

## Verification
byte_ready and rgb are combinational from the burst state and the current inputs, so they are due in the same cycle the inputs are applied. An accepted byte shows on rgb one edge later, and index steps and burst ends also show one edge after the beam_x value that caused them. The bench drives every input on the falling edge and compares both outputs a moment later. Its behavioural model updates on each rising edge from the same inputs, so the expected value always comes from the state that the register chain in the design would hold. Directed cases pin down the exact cycle of pixel 0, of the first scale step and of the burst end, each with a hand-computed value.

// File: rtl/pser_pkg.sv
package pser_pkg;
  localparam int BYTE_W = 8;
  localparam int IDX_W  = $clog2(BYTE_W);

  typedef enum logic [1:0] {
    DEP_1 = 2'd0,
    DEP_2 = 2'd1,
    DEP_4 = 2'd2,
    DEP_4ALT = 2'd3
  } depth_e;

  // colour index bit n drives rgb bit n (red, green, blue)
  function automatic logic [2:0] idx_to_rgb(input logic [3:0] ci);
    return ci[2:0];
  endfunction
endpackage

// File: rtl/pser_decode.sv
module pser_decode
  import pser_pkg::*;
(
  input  logic [BYTE_W-1:0] src,
  input  logic [1:0]        depth,
  input  logic [IDX_W-1:0]  idx,
  output logic [3:0]        ci
);
  logic       ci1;
  logic [1:0] ci2;
  logic [3:0] ci4;
  logic [1:0] i2;
  logic       i1;

  assign i2 = idx[1:0];
  assign i1 = idx[0];

  // 1 bpp: bit 7-i
  assign ci1 = src[~idx];
  // 2 bpp: upper from 7-i, lower from 3-i
  assign ci2 = {src[{1'b1, ~i2}], src[{1'b0, ~i2}]};

  // 4 bpp: index bit k comes from byte bit 2k+1-i
  for (genvar k = 0; k < 4; k++) begin : g_quad
    localparam logic [1:0] KSEL = k[1:0];
    assign ci4[k] = src[{KSEL, ~i1}];
  end

  always_comb begin
    case (depth_e'(depth))
      DEP_1:   ci = {3'b000, ci1};
      DEP_2:   ci = {2'b00, ci2};
      default: ci = ci4;
    endcase
  end
endmodule

// File: rtl/pser_pacer.sv
module pser_pacer
  import pser_pkg::*;
#(
  parameter int X_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              phase0,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic              hold,
  input  logic [X_W-1:0]    beam_x,
  input  logic [1:0]        scale_sel,
  output logic              in_ready,
  output logic              active,
  output logic [IDX_W-1:0]  idx,
  output logic [BYTE_W-1:0] held
);
  localparam int BURST_LOG = 3;

  logic       load;
  logic [1:0] step_mask;
  logic       step_hit;
  logic       end_hit;

  assign in_ready = phase0 & ~active;
  assign load     = in_ready & in_valid;

  always_comb begin
    case (scale_sel)
      2'd0:    step_mask = 2'b00;
      2'd1:    step_mask = 2'b01;
      default: step_mask = 2'b11;
    endcase
  end

  assign step_hit = (beam_x[1:0] & step_mask) == step_mask;
  assign end_hit  = &beam_x[BURST_LOG-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      idx    <= '0;
      held   <= '0;
    end else if (load) begin
      active <= 1'b1;
      idx    <= '0;
      held   <= in_byte;
    end else if (active && !hold) begin
      if (end_hit)  active <= 1'b0;
      if (step_hit) idx    <= idx + 1'b1;
    end
  end

  // R11
  load_starts_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (active && idx == '0));

  // R8
  burst_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !hold && end_hit) |=> !active);

  // R10
  gap_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && hold && !phase0) |=> (active && $stable(idx)));

  // R2
  no_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> $stable(held));

  // R7
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !hold && !step_hit) |=> $stable(idx));
endmodule

// File: rtl/pixel_serializer.sv
module pixel_serializer
  import pser_pkg::*;
#(
  parameter int X_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] pix_byte,
  input  logic              byte_valid,
  output logic              byte_ready,
  input  logic [1:0]        depth_sel,
  input  logic [1:0]        scale_sel,
  input  logic              phase0,
  input  logic [X_W-1:0]    beam_x,
  input  logic              row_gap,
  output logic [2:0]        rgb
);
  logic              active;
  logic [IDX_W-1:0]  idx;
  logic [BYTE_W-1:0] held;
  logic [3:0]        ci;

  pser_pacer #(.X_W(X_W)) u_pacer (
    .clk      (clk),
    .rst_n    (rst_n),
    .phase0   (phase0),
    .in_valid (byte_valid),
    .in_byte  (pix_byte),
    .hold     (row_gap),
    .beam_x   (beam_x),
    .scale_sel(scale_sel),
    .in_ready (byte_ready),
    .active   (active),
    .idx      (idx),
    .held     (held)
  );

  pser_decode u_decode (
    .src  (held),
    .depth(depth_sel),
    .idx  (idx),
    .ci   (ci)
  );

  assign rgb = (active && !row_gap) ? idx_to_rgb(ci) : 3'b000;

  // R9
  idle_black_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !(byte_valid && byte_ready)) |=> (rgb == 3'b000));
endmodule

// File: tb/pixel_serializer_test.sv
module pixel_serializer_test;
  localparam int CLK_PERIOD = 10;
  localparam int XW = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    pix_byte = '0;
  logic          byte_valid = 1'b0;
  logic          byte_ready;
  logic [1:0]    depth_sel = '0;
  logic [1:0]    scale_sel = '0;
  logic          phase0 = 1'b0;
  logic [XW-1:0] beam_x = '0;
  logic          row_gap = 1'b0;
  logic [2:0]    rgb;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  // behavioural model state
  bit     m_active = 0;
  int     m_idx = 0;
  int     m_byte = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pixel_serializer #(.X_W(XW)) uut (
    .clk(clk), .rst_n(rst_n), .pix_byte(pix_byte), .byte_valid(byte_valid),
    .byte_ready(byte_ready), .depth_sel(depth_sel), .scale_sel(scale_sel),
    .phase0(phase0), .beam_x(beam_x), .row_gap(row_gap), .rgb(rgb)
  );

  function automatic int scale_of(input int s);
    return (s == 0) ? 1 : (s == 1) ? 2 : 4;
  endfunction

  // colour index per R3/R4/R5, colour lines per R6
  function automatic int model_rgb(input int b, input int d, input int i);
    int ci;
    ci = 0;
    if (d == 0) begin
      ci = (b >> (7 - (i % 8))) & 1;
    end else if (d == 1) begin
      ci = (((b >> (7 - (i % 4))) & 1) * 2) + ((b >> (3 - (i % 4))) & 1);
    end else begin
      for (int k = 0; k < 4; k++)
        ci = ci * 2 + ((b >> (7 - (i % 2) - 2 * k)) & 1);
    end
    return ci % 8;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_active = 0; m_idx = 0; m_byte = 0;
    end else if (phase0 && !m_active && byte_valid) begin
      m_active = 1; m_idx = 0; m_byte = int'(pix_byte);
    end else if (m_active && !row_gap) begin
      if (int'(beam_x) % scale_of(int'(scale_sel)) == scale_of(int'(scale_sel)) - 1)
        m_idx = m_idx + 1;
      if (int'(beam_x) % 8 == 7) m_active = 0;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic compare_model();
    int er;
    string tag;
    if (row_gap) begin er = 0; tag = "R10"; end
    else if (!m_active) begin er = 0; tag = "R9"; end
    else begin
      er = model_rgb(m_byte, int'(depth_sel), m_idx);
      tag = (depth_sel == 0) ? "R3/R6/R7" : (depth_sel == 1) ? "R4/R6/R7" : "R5/R6/R7";
    end
    check(int'(rgb) == er, tag, int'(rgb), er);
    check(byte_ready == (phase0 && !m_active), "R2", int'(byte_ready),
          int'(phase0 && !m_active));
  endtask

  task automatic step(input int x, input bit ph, input bit v, input int b, input bit gap);
    @(negedge clk);
    beam_x = XW'(x); phase0 = ph; byte_valid = v; pix_byte = 8'(b); row_gap = gap;
    #1;
    compare_model();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    int x;
    // R1: reset state
    @(negedge clk); phase0 = 1'b1; byte_valid = 1'b1; pix_byte = 8'hFF; #1;
    check(rgb == 3'b000, "R1", int'(rgb), 0);
    check(byte_ready == 1'b1, "R1", int'(byte_ready), 1);
    @(negedge clk); rst_n = 1'b1; phase0 = 1'b0; byte_valid = 1'b0; #1;
    check(rgb == 3'b000, "R1", int'(rgb), 0);

    // R11/R5/R6/R7/R8 directed: 4 bpp, x4, byte B4
    depth_sel = 2'd2; scale_sel = 2'd2;
    step(1, 1, 1, 8'hB4, 0);
    step(2, 0, 0, 0, 0);
    check(rgb == 3'b100, "R11/R5/R6", int'(rgb), 4);
    step(3, 0, 0, 0, 0);
    check(rgb == 3'b100, "R7", int'(rgb), 4);
    step(4, 0, 0, 0, 0);
    check(rgb == 3'b110, "R7/R5", int'(rgb), 6);
    step(5, 0, 0, 0, 0); step(6, 0, 0, 0, 0); step(7, 0, 0, 0, 0);
    step(8, 0, 0, 0, 0);
    check(rgb == 3'b000, "R8", int'(rgb), 0);

    // R2 directed: valid while busy is not taken
    depth_sel = 2'd0; scale_sel = 2'd0;
    step(8, 1, 1, 8'h80, 0);
    step(9, 1, 1, 8'h00, 0);
    check(rgb == 3'b001, "R3", int'(rgb), 1);
    check(byte_ready == 1'b0, "R2", int'(byte_ready), 0);
    step(10, 0, 0, 0, 1);
    check(rgb == 3'b000, "R10", int'(rgb), 0);

    // model-compared sweeps over depth/scale pairs
    for (int c = 0; c < 8; c++) begin
      depth_sel = 2'(c % 4 == 3 ? 2 : c % 3);
      scale_sel = 2'(c % 4);
      x = 0;
      for (int n = 0; n < 300; n++) begin
        bit ph;
        ph = (c < 4) ? (x % 8 == 7) : ($urandom % 3 == 0);
        step(x, ph, ($urandom % 4) != 0, int'($urandom % 256),
             ($urandom % 12) == 0);
        x = (x + 1) % 1024;
      end
    end

    // R1 again: reset mid-burst
    step(0, 1, 1, 8'hFF, 0);
    @(negedge clk); rst_n = 1'b0; phase0 = 1'b0; byte_valid = 1'b0;
    @(negedge clk); #1;
    check(rgb == 3'b000, "R1", int'(rgb), 0);
    finish_run();
  end
endmodule